// File: doc/BRIEF.md
# OTG Transceiver Mode and Pin-Function Controller

This block is the digital control core of a full-speed OTG line transceiver. It holds three 8-bit configuration registers that software changes through set and clear writes. It combines them with the speed, suspend and active-low output-enable pins to decide four things: the operating mode (USB, UART, transparent I2C bridge or audio), the power state, the driver speed, and which way the data/SE0 digital pins point.

From the same state it produces the enables for the analog side:
- the D+/D- pull-up and pull-down resistors;
- the ID ground switch;
- the internal VBUS pump and the VBUS discharge and charge resistors;
- the shared address/switch pin, which can drive an external VBUS switch.

The level on that shared pin is captured while reset is held. The captured bit serves as the serial-bus address LSB, and it also fixes the polarity of the switch output. Every control output is registered, so it follows a register write or a pin change by one clock.

Register layout (bit 0 is the LSB):
- **CFG_A** (select 0): bit 0 full-speed request, bit 1 sleep request, bit 2 data/SE0 encoding, bit 3 UART request, bit 4 bridge request.
- **CFG_B** (select 1): bit 0 VBUS source, bit 1 VBUS discharge, bit 2 VBUS charge, bit 3 ID ground, bit 4 D+ pull-up, bit 5 D- pull-up, bit 6 D+ pull-down, bit 7 D- pull-down.
- **CFG_C** (select 2): bit 0 bidirectional pins, bit 1 UART direction 0, bit 2 UART direction 1, bit 3 external pump.

Top module: `otg_xcvr_ctrl`

## Requirements
- R1: `full_speed_o` is 1 only when CFG_A bit 0 and `speed_i` are both 1; otherwise low-speed (0) is reported.
- R2: `power_down_o` is 1 only when CFG_A bit 1 and `suspend_i` are both 1.
- R3: `mode_o` encodes USB=0, UART=1, bridge=2, audio=3. The UART request wins over the bridge request. A write that leaves both requests set keeps only the UART request, so clearing the UART request afterwards returns to USB.
- R4: With neither request set, `oe_n_i` high and CFG_B all zero, the mode is audio (3). In audio mode every pull, ID-ground and VBUS enable is 0.
- R5: With CFG_C bit 0 set, `dat_pins_out_o` equals `oe_n_i`. With it clear, `dat_pins_out_o` is 0.
- R6: `dse_enc_o` reflects CFG_A bit 2 (1 = data+SE0 encoding, 0 = separate line encoding). `line_tx_en_o` is 1 only in USB mode with `oe_n_i` low.
- R7: Of CFG_B bits 0, 1 and 2, at most one stays set after any write. The priority is bit 0 over bit 1 over bit 2.
- R8: With CFG_C bit 3 set, `psw_oe_o` is 1 and `pump_en_o` is 0. With it clear, `psw_oe_o` is 0 and `pump_en_o` follows CFG_B bit 0.
- R9: `addr_lsb_o` holds the `adr_psw_i` level from the last reset cycle, and later pin changes are ignored. `psw_o` is that bit XOR CFG_B bit 0, so the output is active low when the captured level was 1.
- R10: After reset: CFG_A=0x03, CFG_B=0xC0, CFG_C=0x05, and all other bits are 0.
- R11: In bridge mode `dp_pu_en_o` is 1 whatever CFG_B bit 4 holds, and `i2c_mirror_en_o` equals NOT `oe_n_i`.
- R12: A write with `wr_clr`=0 ORs `wr_data` into the selected register, and one with `wr_clr`=1 clears the bits set in `wr_data`. Select 3 writes nothing. Outputs change one clock after the write edge.
- R13: `uart_dir_o` is {CFG_C bit 2, CFG_C bit 1} in UART mode and 0 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 A, 1 B, 2 C) |
| wr_clr | input | 1 | 0 = set bits, 1 = clear bits |
| wr_data | input | 8 | Bit mask to set or clear |
| speed_i | input | 1 | Speed pin (1 = full-speed allowed) |
| suspend_i | input | 1 | Suspend pin |
| oe_n_i | input | 1 | Active-low output-enable pin |
| adr_psw_i | input | 1 | Level on shared address/switch pin |
| mode_o | output | 2 | Operating mode |
| full_speed_o | output | 1 | Driver speed select |
| power_down_o | output | 1 | Power-down state |
| dse_enc_o | output | 1 | Data+SE0 encoding selected |
| dat_pins_out_o | output | 1 | Data/SE0 pins carry receiver results |
| line_tx_en_o | output | 1 | Differential driver enable |
| i2c_mirror_en_o | output | 1 | Bridge mirror paths enabled |
| dp_pu_en_o | output | 1 | D+ pull-up enable |
| dm_pu_en_o | output | 1 | D- pull-up enable |
| dp_pd_en_o | output | 1 | D+ pull-down enable |
| dm_pd_en_o | output | 1 | D- pull-down enable |
| id_gnd_en_o | output | 1 | ID ground switch enable |
| pump_en_o | output | 1 | Internal VBUS pump enable |
| vbus_dis_en_o | output | 1 | VBUS discharge enable |
| vbus_chg_en_o | output | 1 | VBUS charge enable |
| psw_oe_o | output | 1 | Shared pin driven as switch output |
| psw_o | output | 1 | Switch output level |
| uart_dir_o | output | 2 | UART line directions |
| addr_lsb_o | output | 1 | Captured address LSB |

## Verification
Audio mode is the hardest state to reach. It needs every line-control bit cleared, including the two pull-downs that come out of reset set, plus both mode requests clear and the enable pin high. The stimulus clears CFG_B fully and then toggles `oe_n_i` to move between audio and USB. A further case sets the UART request on top, which must override audio.

The polarity of the switch output is fixed only by the shared pin's level during reset. The stimulus therefore runs two separate resets, one with the pin high and one with it low, and flips the pin after each reset. This shows that neither the captured address bit nor the switch polarity follows the live pin.

// File: rtl/xcvr_ctrl_pkg.sv
package xcvr_ctrl_pkg;
  parameter int CFG_W   = 8;
  parameter int NUM_CFG = 3;
  parameter int SEL_W   = 2;

  typedef enum logic [1:0] {
    MODE_USB    = 2'd0,
    MODE_UART   = 2'd1,
    MODE_BRIDGE = 2'd2,
    MODE_AUDIO  = 2'd3
  } xcvr_mode_e;

  // CFG_A bit positions
  localparam int A_FS     = 0;
  localparam int A_SLEEP  = 1;
  localparam int A_DSE    = 2;
  localparam int A_UART   = 3;
  localparam int A_BRIDGE = 4;
  // CFG_B bit positions (VBUS bits ordered by priority)
  localparam int B_VSRC  = 0;
  localparam int B_VDIS  = 1;
  localparam int B_VCHG  = 2;
  localparam int B_IDGND = 3;
  localparam int B_DPPU  = 4;
  localparam int B_DMPU  = 5;
  localparam int B_DPPD  = 6;
  localparam int B_DMPD  = 7;
  // CFG_C bit positions
  localparam int C_BIDIR = 0;
  localparam int C_UDIR0 = 1;
  localparam int C_UDIR1 = 2;
  localparam int C_EXTP  = 3;

  typedef struct packed {
    xcvr_mode_e  mode;
    logic        full_speed;
    logic        power_down;
    logic        dse_enc;
    logic        dat_pins_out;
    logic        line_tx_en;
    logic        i2c_mirror_en;
    logic        dp_pu;
    logic        dm_pu;
    logic        dp_pd;
    logic        dm_pd;
    logic        id_gnd;
    logic        pump_en;
    logic        vb_dis;
    logic        vb_chg;
    logic        psw_oe;
    logic        psw;
    logic [1:0]  uart_dir;
  } xcvr_ctl_t;

  function automatic logic [CFG_W-1:0] cfg_reset(input int idx);
    logic [CFG_W-1:0] v;
    v = '0;
    case (idx)
      0: begin v[A_FS] = 1'b1; v[A_SLEEP] = 1'b1; end
      1: begin v[B_DPPD] = 1'b1; v[B_DMPD] = 1'b1; end
      default: begin v[C_BIDIR] = 1'b1; v[C_UDIR1] = 1'b1; end
    endcase
    return v;
  endfunction

  // Resolve bit combinations that may not coexist.
  function automatic logic [CFG_W-1:0] cfg_fix(input int idx, input logic [CFG_W-1:0] v);
    logic [CFG_W-1:0] r;
    r = v;
    if (idx == 0) begin
      if (r[A_UART]) r[A_BRIDGE] = 1'b0;
    end else if (idx == 1) begin
      if (r[B_VSRC]) begin
        r[B_VDIS] = 1'b0;
        r[B_VCHG] = 1'b0;
      end else if (r[B_VDIS]) begin
        r[B_VCHG] = 1'b0;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/xcvr_cfg_regs.sv
module xcvr_cfg_regs
  import xcvr_ctrl_pkg::*;
#(
  parameter int W  = CFG_W,
  parameter int N  = NUM_CFG,
  parameter int SW = SEL_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_sel,
  input  logic           wr_clr,
  input  logic [W-1:0]   wr_data,
  output logic [N*W-1:0] cfg_flat
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] q;
    logic [W-1:0] upd;
    assign upd = wr_clr ? (q & ~wr_data) : (q | wr_data);
    always_ff @(posedge clk) begin
      if (rst)
        q <= W'(cfg_reset(g));
      else if (wr_en && (int'(wr_sel) == g))
        q <= W'(cfg_fix(g, CFG_W'(upd)));
    end
    assign cfg_flat[g*W +: W] = q;
  end
endmodule

// File: rtl/xcvr_psw_latch.sv
module xcvr_psw_latch (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lat_o
);
  // The level seen in the last reset cycle is kept once reset releases.
  always_ff @(posedge clk) begin
    if (rst) lat_o <= pin_i;
  end
endmodule

// File: rtl/xcvr_mode_decode.sv
module xcvr_mode_decode
  import xcvr_ctrl_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic [W-1:0] cfg_a,
  input  logic [W-1:0] cfg_b,
  input  logic [W-1:0] cfg_c,
  input  logic         speed_i,
  input  logic         suspend_i,
  input  logic         oe_n_i,
  input  logic         psw_lat,
  output xcvr_ctl_t    ctl
);
  logic audio;
  logic bridge;

  always_comb begin
    ctl = '0;
    if (cfg_a[A_UART])
      ctl.mode = MODE_UART;
    else if (cfg_a[A_BRIDGE])
      ctl.mode = MODE_BRIDGE;
    else if (oe_n_i && (cfg_b == '0))
      ctl.mode = MODE_AUDIO;
    else
      ctl.mode = MODE_USB;
    audio  = (ctl.mode == MODE_AUDIO);
    bridge = (ctl.mode == MODE_BRIDGE);

    ctl.full_speed    = cfg_a[A_FS] & speed_i;
    ctl.power_down    = cfg_a[A_SLEEP] & suspend_i;
    ctl.dse_enc       = cfg_a[A_DSE];
    ctl.dat_pins_out  = cfg_c[C_BIDIR] & oe_n_i;
    ctl.line_tx_en    = (ctl.mode == MODE_USB) & ~oe_n_i;
    ctl.i2c_mirror_en = bridge & ~oe_n_i;

    ctl.dp_pu  = ~audio & (cfg_b[B_DPPU] | bridge);
    ctl.dm_pu  = ~audio & cfg_b[B_DMPU];
    ctl.dp_pd  = ~audio & cfg_b[B_DPPD];
    ctl.dm_pd  = ~audio & cfg_b[B_DMPD];
    ctl.id_gnd = ~audio & cfg_b[B_IDGND];

    ctl.pump_en = ~audio & cfg_b[B_VSRC] & ~cfg_c[C_EXTP];
    ctl.vb_dis  = ~audio & cfg_b[B_VDIS];
    ctl.vb_chg  = ~audio & cfg_b[B_VCHG];
    ctl.psw_oe  = cfg_c[C_EXTP];
    ctl.psw     = cfg_c[C_EXTP] & (psw_lat ^ (cfg_b[B_VSRC] & ~audio));

    ctl.uart_dir = (ctl.mode == MODE_UART) ? {cfg_c[C_UDIR1], cfg_c[C_UDIR0]} : 2'b00;
  end
endmodule

// File: rtl/otg_xcvr_ctrl.sv
module otg_xcvr_ctrl
  import xcvr_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic       wr_clr,
  input  logic [7:0] wr_data,
  input  logic       speed_i,
  input  logic       suspend_i,
  input  logic       oe_n_i,
  input  logic       adr_psw_i,
  output logic [1:0] mode_o,
  output logic       full_speed_o,
  output logic       power_down_o,
  output logic       dse_enc_o,
  output logic       dat_pins_out_o,
  output logic       line_tx_en_o,
  output logic       i2c_mirror_en_o,
  output logic       dp_pu_en_o,
  output logic       dm_pu_en_o,
  output logic       dp_pd_en_o,
  output logic       dm_pd_en_o,
  output logic       id_gnd_en_o,
  output logic       pump_en_o,
  output logic       vbus_dis_en_o,
  output logic       vbus_chg_en_o,
  output logic       psw_oe_o,
  output logic       psw_o,
  output logic [1:0] uart_dir_o,
  output logic       addr_lsb_o
);
  localparam int FLAT_W = NUM_CFG * CFG_W;

  logic [FLAT_W-1:0] cfg_flat;
  logic              psw_lat;
  xcvr_ctl_t         ctl_d;
  xcvr_ctl_t         ctl_q;

  xcvr_cfg_regs #(.W(CFG_W), .N(NUM_CFG), .SW(SEL_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_clr   (wr_clr),
    .wr_data  (wr_data),
    .cfg_flat (cfg_flat)
  );

  xcvr_psw_latch u_lat (
    .clk   (clk),
    .rst   (rst),
    .pin_i (adr_psw_i),
    .lat_o (psw_lat)
  );

  xcvr_mode_decode #(.W(CFG_W)) u_dec (
    .cfg_a     (cfg_flat[0*CFG_W +: CFG_W]),
    .cfg_b     (cfg_flat[1*CFG_W +: CFG_W]),
    .cfg_c     (cfg_flat[2*CFG_W +: CFG_W]),
    .speed_i   (speed_i),
    .suspend_i (suspend_i),
    .oe_n_i    (oe_n_i),
    .psw_lat   (psw_lat),
    .ctl       (ctl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

  assign mode_o          = ctl_q.mode;
  assign full_speed_o    = ctl_q.full_speed;
  assign power_down_o    = ctl_q.power_down;
  assign dse_enc_o       = ctl_q.dse_enc;
  assign dat_pins_out_o  = ctl_q.dat_pins_out;
  assign line_tx_en_o    = ctl_q.line_tx_en;
  assign i2c_mirror_en_o = ctl_q.i2c_mirror_en;
  assign dp_pu_en_o      = ctl_q.dp_pu;
  assign dm_pu_en_o      = ctl_q.dm_pu;
  assign dp_pd_en_o      = ctl_q.dp_pd;
  assign dm_pd_en_o      = ctl_q.dm_pd;
  assign id_gnd_en_o     = ctl_q.id_gnd;
  assign pump_en_o       = ctl_q.pump_en;
  assign vbus_dis_en_o   = ctl_q.vb_dis;
  assign vbus_chg_en_o   = ctl_q.vb_chg;
  assign psw_oe_o        = ctl_q.psw_oe;
  assign psw_o           = ctl_q.psw;
  assign uart_dir_o      = ctl_q.uart_dir;
  assign addr_lsb_o      = psw_lat;
endmodule

// File: rtl/xcvr_ctrl_chk.sv
module xcvr_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       speed_i,
  input logic       suspend_i,
  input logic       oe_n_i,
  input logic [1:0] mode_o,
  input logic       full_speed_o,
  input logic       power_down_o,
  input logic       dat_pins_out_o,
  input logic       dp_pu_en_o,
  input logic       dm_pu_en_o,
  input logic       dp_pd_en_o,
  input logic       dm_pd_en_o,
  input logic       id_gnd_en_o,
  input logic       pump_en_o,
  input logic       vbus_dis_en_o,
  input logic       vbus_chg_en_o,
  input logic       psw_oe_o,
  input logic       addr_lsb_o
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1
  low_speed_pin_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(speed_i) |-> !full_speed_o);
  // R2
  awake_pin_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(suspend_i) |-> !power_down_o);
  // R4
  audio_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
    armed && mode_o == 2'd3 |-> $past(oe_n_i));
  // R4
  audio_released_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'd3 |-> !(dp_pu_en_o | dm_pu_en_o | dp_pd_en_o | dm_pd_en_o |
                        id_gnd_en_o | pump_en_o | vbus_dis_en_o | vbus_chg_en_o));
  // R5
  pins_in_when_oe_low_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(oe_n_i) |-> !dat_pins_out_o);
  // R7
  vbus_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pump_en_o, vbus_dis_en_o, vbus_chg_en_o}));
  // R8
  ext_pump_excl_chk: assert property (@(posedge clk) disable iff (rst)
    psw_oe_o |-> !pump_en_o);
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> $stable(addr_lsb_o));
  // R11
  bridge_pullup_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'd2 |-> dp_pu_en_o);
endmodule

bind otg_xcvr_ctrl xcvr_ctrl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .speed_i        (speed_i),
  .suspend_i      (suspend_i),
  .oe_n_i         (oe_n_i),
  .mode_o         (mode_o),
  .full_speed_o   (full_speed_o),
  .power_down_o   (power_down_o),
  .dat_pins_out_o (dat_pins_out_o),
  .dp_pu_en_o     (dp_pu_en_o),
  .dm_pu_en_o     (dm_pu_en_o),
  .dp_pd_en_o     (dp_pd_en_o),
  .dm_pd_en_o     (dm_pd_en_o),
  .id_gnd_en_o    (id_gnd_en_o),
  .pump_en_o      (pump_en_o),
  .vbus_dis_en_o  (vbus_dis_en_o),
  .vbus_chg_en_o  (vbus_chg_en_o),
  .psw_oe_o       (psw_oe_o),
  .addr_lsb_o     (addr_lsb_o)
);

// File: tb/otg_xcvr_ctrl_bench.sv
`timescale 1ns/1ps
module otg_xcvr_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic wr_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic speed_i = 1'b1, suspend_i = 1'b1, oe_n_i = 1'b0, adr_psw_i = 1'b0;
  logic [1:0] mode_o, uart_dir_o;
  logic full_speed_o, power_down_o, dse_enc_o, dat_pins_out_o, line_tx_en_o;
  logic i2c_mirror_en_o, dp_pu_en_o, dm_pu_en_o, dp_pd_en_o, dm_pd_en_o;
  logic id_gnd_en_o, pump_en_o, vbus_dis_en_o, vbus_chg_en_o, psw_oe_o, psw_o, addr_lsb_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  otg_xcvr_ctrl u_otg_xcvr_ctrl (.*);

  // {cfg_a, speed, suspend, oe_n, mode, full_speed, power_down}; CFG_B held at 0x10
  localparam logic [14:0] TBL [0:10] = '{
    {8'h03, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1},
    {8'h03, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1},
    {8'h02, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1},
    {8'h01, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0},
    {8'h03, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},
    {8'h08, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0},
    {8'h10, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0},
    {8'h18, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0},
    {8'h13, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
    {8'h07, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic clr, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_clr = clr; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic adr);
    @(negedge clk);
    rst = 1'b1; adr_psw_i = adr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    adr_psw_i = ~adr;
    settle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    speed_i = 1'b1; suspend_i = 1'b1; oe_n_i = 1'b0;
    do_reset(1'b1);
    // R10 reset state
    chk("R10", "mode", 8'(mode_o), 8'd0);
    chk("R10", "fs", 8'(full_speed_o), 8'd1);
    chk("R10", "pd", 8'(power_down_o), 8'd1);
    chk("R10", "pulls", 8'({dp_pu_en_o, dm_pu_en_o, dp_pd_en_o, dm_pd_en_o}), 8'b0011);
    chk("R10", "vbus", 8'({pump_en_o, vbus_dis_en_o, vbus_chg_en_o, id_gnd_en_o, psw_oe_o}), 8'd0);
    chk("R10", "dse", 8'(dse_enc_o), 8'd0);
    chk("R6", "tx_en", 8'(line_tx_en_o), 8'd1);
    chk("R9", "addr lsb held", 8'(addr_lsb_o), 8'd1);
    // R5 bidirectional pins at reset (bidir=1)
    chk("R5", "oe low pins in", 8'(dat_pins_out_o), 8'd0);
    oe_n_i = 1'b1; settle();
    chk("R5", "oe high pins out", 8'(dat_pins_out_o), 8'd1);
    chk("R6", "tx_en oe high", 8'(line_tx_en_o), 8'd0);
    wr(2'd2, 1'b1, 8'h01); settle();
    chk("R5", "bidir off", 8'(dat_pins_out_o), 8'd0);
    wr(2'd2, 1'b0, 8'h01);

    // table walk: R1 R2 R3
    wr(2'd1, 1'b1, 8'hFF);
    wr(2'd1, 1'b0, 8'h10);
    for (int i = 0; i < 11; i++) begin
      logic [14:0] e;
      e = TBL[i];
      wr(2'd0, 1'b1, 8'hFF);
      wr(2'd0, 1'b0, e[14:7]);
      speed_i = e[6]; suspend_i = e[5]; oe_n_i = e[4];
      settle();
      chk("R3", $sformatf("row %0d mode", i), 8'(mode_o), 8'(e[3:2]));
      chk("R1", $sformatf("row %0d fs", i), 8'(full_speed_o), 8'(e[1]));
      chk("R2", $sformatf("row %0d pd", i), 8'(power_down_o), 8'(e[0]));
    end
    // row 10 had cfg_a=0x07
    chk("R6", "dse set", 8'(dse_enc_o), 8'd1);

    // R3 bridge dropped when both requested
    wr(2'd0, 1'b1, 8'hFF);
    wr(2'd0, 1'b0, 8'h18);
    wr(2'd0, 1'b1, 8'h08); settle();
    chk("R3", "bridge dropped", 8'(mode_o), 8'd0);

    // R11 bridge pull-up and mirror
    oe_n_i = 1'b0;
    wr(2'd1, 1'b1, 8'h10);
    wr(2'd0, 1'b0, 8'h10); settle();
    chk("R11", "dp pull-up", 8'(dp_pu_en_o), 8'd1);
    chk("R11", "mirror oe low", 8'(i2c_mirror_en_o), 8'd1);
    oe_n_i = 1'b1; settle();
    chk("R11", "mirror oe high", 8'(i2c_mirror_en_o), 8'd0);
    chk("R4", "bridge not audio", 8'(mode_o), 8'd2);

    // R4 audio
    wr(2'd0, 1'b1, 8'h10); settle();
    chk("R4", "audio mode", 8'(mode_o), 8'd3);
    chk("R4", "all released", 8'({dp_pu_en_o, dm_pu_en_o, dp_pd_en_o, dm_pd_en_o, id_gnd_en_o, pump_en_o}), 8'd0);
    oe_n_i = 1'b0; settle();
    chk("R4", "oe low usb", 8'(mode_o), 8'd0);
    oe_n_i = 1'b1;
    wr(2'd0, 1'b0, 8'h08); settle();
    chk("R4", "uart over audio", 8'(mode_o), 8'd1);
    // R13 uart dir at reset value of CFG_C
    chk("R13", "uart dir", 8'(uart_dir_o), 8'b10);
    wr(2'd2, 1'b0, 8'h02); settle();
    chk("R13", "uart dir both", 8'(uart_dir_o), 8'b11);
    wr(2'd0, 1'b1, 8'h08); settle();
    chk("R13", "dir zero outside uart", 8'(uart_dir_o), 8'd0);

    // R7 VBUS priority
    oe_n_i = 1'b0;
    wr(2'd1, 1'b0, 8'h07); settle();
    chk("R7", "src wins", 8'({pump_en_o, vbus_dis_en_o, vbus_chg_en_o}), 8'b100);
    wr(2'd1, 1'b1, 8'h01); settle();
    chk("R7", "others cleared", 8'({pump_en_o, vbus_dis_en_o, vbus_chg_en_o}), 8'b000);
    wr(2'd1, 1'b0, 8'h06); settle();
    chk("R7", "dis over chg", 8'({pump_en_o, vbus_dis_en_o, vbus_chg_en_o}), 8'b010);
    wr(2'd1, 1'b0, 8'h01); settle();
    chk("R7", "src over dis", 8'({pump_en_o, vbus_dis_en_o, vbus_chg_en_o}), 8'b100);

    // R12 select 3 writes nothing
    wr(2'd3, 1'b0, 8'hFF); settle();
    chk("R12", "sel3 ignored mode", 8'(mode_o), 8'd0);
    chk("R12", "sel3 ignored pulls", 8'({dp_pu_en_o, dm_pu_en_o, id_gnd_en_o}), 8'd0);
    // R12 one-clock latency
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_clr = 1'b0; wr_data = 8'h20;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R12", "not yet visible", 8'(dm_pu_en_o), 8'd0);
    @(negedge clk);
    chk("R12", "visible next clock", 8'(dm_pu_en_o), 8'd1);

    // R8 R9 external switch, captured high
    wr(2'd2, 1'b0, 8'h08); settle();
    chk("R8", "psw oe", 8'(psw_oe_o), 8'd1);
    chk("R8", "pump off", 8'(pump_en_o), 8'd0);
    chk("R9", "active low asserted", 8'(psw_o), 8'd0);
    wr(2'd1, 1'b1, 8'h01); settle();
    chk("R9", "active low idle", 8'(psw_o), 8'd1);
    wr(2'd2, 1'b1, 8'h08);
    wr(2'd1, 1'b0, 8'h01); settle();
    chk("R8", "internal pump", 8'({psw_oe_o, pump_en_o}), 8'b01);

    // R9 captured low
    do_reset(1'b0);
    chk("R9", "addr lsb low", 8'(addr_lsb_o), 8'd0);
    wr(2'd2, 1'b0, 8'h08);
    wr(2'd1, 1'b0, 8'h01); settle();
    chk("R9", "active high asserted", 8'(psw_o), 8'd1);
    wr(2'd1, 1'b1, 8'h01); settle();
    chk("R9", "active high idle", 8'(psw_o), 8'd0);
    chk("R9", "addr ignores pin", 8'(addr_lsb_o), 8'd0);

    summary();
  end
endmodule